// File: doc/BRIEF.md
# Timer Control and External Interrupt Request Register

This block is one byte of control and status state inside a small 8-bit microcontroller. It holds the run enables of two timers, the overflow flags those timers raise, and the request flags of two external interrupt pins. Software reads the whole byte and writes any subset of its bits through a per-bit write mask. Timers report overflow with single-cycle pulses. The interrupt controller reports which handler the CPU has just entered through vector-acknowledge strobes.

Each external pin passes through a two-flop synchronizer. It is then compared against a polarity input that selects active-high or active-low. A per-pin mode bit picks how the request flag behaves. In level mode the flag follows the synchronized active level. In edge mode the flag latches on each transition into the active level and stays set until a vector acknowledge or a software write clears it.

Each pin has a two-state tracker with the states PIN_IDLE and PIN_ACTIVE. The tracker moves from PIN_IDLE to PIN_ACTIVE when the synchronized pin reaches its active level. That transition is the edge event. It moves from PIN_ACTIVE back to PIN_IDLE when the pin leaves its active level. In every other cycle it holds its state.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset the register reads 0x00, and tmr_run and irq_req are all zero.
- R2: The read layout from bit 7 down to bit 0 is: timer-1 overflow flag, timer-1 run, timer-0 overflow flag, timer-0 run, pin-1 request, pin-1 mode, pin-0 request, pin-0 mode. A mode bit of 1 selects edge detection and 0 selects level detection. irq_req is {bit7, bit5, bit3, bit1}, and tmr_run is {bit6, bit4}.
- R3: A write changes only the bits whose wr_mask bit is 1. Run and mode bits take the written value on the next clock edge.
- R4: A tmr_ovf pulse sets its timer's overflow flag on the next clock edge. A masked software write sets or clears that flag.
- R5: vec_ack_tmr[i] clears only timer i's overflow flag.
- R6: When a set event and a clear (write of 0 or acknowledge) hit the same bit in the same cycle, the bit ends up 1.
- R7: A pin change reaches the request flag on the third rising clock edge after the change.
- R8: In level mode the request flag equals the synchronized active level. Software writes and vec_ack_ext leave it unchanged.
- R9: In edge mode the request flag is set by a transition into the active level. It stays set after the pin goes inactive. A pin that stays active sets it again only after a new transition.
- R10: In edge mode vec_ack_ext[i] or a software write of 0 clears request flag i. An acknowledge of the other pin leaves it unchanged.
- R11: ext_pol[i]=1 makes pin i active-high, and ext_pol[i]=0 makes it active-low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_mask | input | 8 | Per-bit write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register contents |
| tmr_ovf | input | 2 | Timer overflow pulses, index = timer |
| vec_ack_tmr | input | 2 | Vector acknowledge for the timer interrupts |
| ext_pin | input | 2 | External interrupt pins (asynchronous) |
| ext_pol | input | 2 | Pin polarity, 1 = active-high |
| vec_ack_ext | input | 2 | Vector acknowledge for the pin interrupts |
| tmr_run | output | 2 | Timer run enables |
| irq_req | output | 4 | Requests {tmr1, tmr0, pin1, pin0} |

## Verification
The assertions assume that ext_pol does not change while a pin is being watched. A polarity flip looks like a pin transition, so it would set an edge-mode flag. The assertions also assume that overflow and acknowledge strobes last one cycle. The stimulus changes polarity only while that pin is in level mode or inactive under both polarities. It drives every strobe for exactly one clock. It changes pins only at falling edges and waits the full synchronizer latency before it checks.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_TMR = 2;
    localparam int NUM_EXT = 2;

    typedef enum logic {
        PIN_IDLE   = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

    function automatic int tf_pos(input int i);
        return 5 + 2 * i;
    endfunction

    function automatic int tr_pos(input int i);
        return 4 + 2 * i;
    endfunction

    function automatic int ie_pos(input int i);
        return 1 + 2 * i;
    endfunction

    function automatic int it_pos(input int i);
        return 2 * i;
    endfunction
endpackage

// File: rtl/tic_tmr_chan.sv
module tic_tmr_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic ack,
    input  logic wr_flag,
    input  logic wd_flag,
    input  logic wr_run,
    input  logic wd_run,
    output logic flag,
    output logic run
);
    logic flag_q, flag_d;
    logic run_q;

    always_comb begin
        flag_d = flag_q;
        if (wr_flag) flag_d = wd_flag;
        if (ack)     flag_d = 1'b0;
        if (ovf)     flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (wr_run) run_q <= wd_run;
        end
    end

    assign flag = flag_q;
    assign run  = run_q;

    // R4
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ovf) |=> !flag_q);

    // R3
    run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_run |=> (run_q == $past(wd_run)));
endmodule

// File: rtl/tic_ext_chan.sv
module tic_ext_chan
    import tic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic edge_mode,
    input  logic ack,
    input  logic wr_flag,
    input  logic wd_flag,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   active;
    logic                   rise;
    pin_state_e             state_q, state_d;
    logic                   flag_q, flag_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign active = pol ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            PIN_IDLE: begin
                if (active) begin
                    state_d = PIN_ACTIVE;
                    rise    = 1'b1;
                end
            end
            PIN_ACTIVE: begin
                if (!active) state_d = PIN_IDLE;
            end
        endcase
    end

    always_comb begin
        if (!edge_mode) begin
            flag_d = active;
        end else begin
            flag_d = flag_q;
            if (wr_flag) flag_d = wd_flag;
            if (ack)     flag_d = 1'b0;
            if (rise)    flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R9
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && rise) |=> flag_q);

    // R8
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> (flag_q == $past(active)));

    // R10
    edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !rise) |=> !flag_q);
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] wr_mask,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [1:0]       tmr_ovf,
    input  logic [1:0]       vec_ack_tmr,
    input  logic [1:0]       ext_pin,
    input  logic [1:0]       ext_pol,
    input  logic [1:0]       vec_ack_ext,
    output logic [1:0]       tmr_run,
    output logic [3:0]       irq_req
);
    logic [NUM_TMR-1:0] tf, tr;
    logic [NUM_EXT-1:0] ie, mode_q;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tic_tmr_chan u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ovf     (tmr_ovf[i]),
            .ack     (vec_ack_tmr[i]),
            .wr_flag (wr_mask[tf_pos(i)]),
            .wd_flag (wr_data[tf_pos(i)]),
            .wr_run  (wr_mask[tr_pos(i)]),
            .wd_run  (wr_data[tr_pos(i)]),
            .flag    (tf[i]),
            .run     (tr[i])
        );
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   mode_q[i] <= 1'b0;
            else if (wr_mask[it_pos(i)])  mode_q[i] <= wr_data[it_pos(i)];
        end

        tic_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (ext_pin[i]),
            .pol       (ext_pol[i]),
            .edge_mode (mode_q[i]),
            .ack       (vec_ack_ext[i]),
            .wr_flag   (wr_mask[ie_pos(i)]),
            .wd_flag   (wr_data[ie_pos(i)]),
            .flag      (ie[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            rd_data[tf_pos(i)] = tf[i];
            rd_data[tr_pos(i)] = tr[i];
        end
        for (int i = 0; i < NUM_EXT; i++) begin
            rd_data[ie_pos(i)] = ie[i];
            rd_data[it_pos(i)] = mode_q[i];
        end
    end

    assign tmr_run = tr;
    assign irq_req = {tf[1], tf[0], ie[1], ie[0]};

    // R3
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask[0] |=> (rd_data[0] == $past(wr_data[0])));
endmodule

// File: tb/sim_tmr_irq_ctl.sv
module sim_tmr_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_mask = '0, wr_data = '0, rd_data;
    logic [1:0] tmr_ovf = '0, vec_ack_tmr = '0, ext_pin = '0, ext_pol = 2'b11, vec_ack_ext = '0;
    logic [1:0] tmr_run;
    logic [3:0] irq_req;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    typedef struct {
        logic [13:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    tmr_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_data(wr_data),
        .rd_data(rd_data), .tmr_ovf(tmr_ovf), .vec_ack_tmr(vec_ack_tmr),
        .ext_pin(ext_pin), .ext_pol(ext_pol), .vec_ack_ext(vec_ack_ext),
        .tmr_run(tmr_run), .irq_req(irq_req)
    );

    function automatic logic [13:0] expand(input logic [7:0] r);
        return {r[7], r[5], r[3], r[1], r[6], r[4], r};
    endfunction

    task automatic expect_reg(input logic [7:0] r, input string tag);
        item_t it;
        it.exp = expand(r);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] m, input logic [7:0] d);
        wr_mask = m; wr_data = d;
        tick(1);
        wr_mask = '0; wr_data = '0;
    endtask

    // monitor: compares the outputs shortly after each falling edge
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [13:0] obs;
            it  = sb_q.pop_front();
            obs = {irq_req, tmr_run, rd_data};
            n_chk++;
            if (obs !== it.exp) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_reg(8'h00, "R1 reset");
        wr(8'hFF, 8'h55);
        expect_reg(8'h55, "R2 R3 full write");
        wr(8'h40, 8'h00);
        expect_reg(8'h15, "R3 masked write");
        // timer flags
        tmr_ovf = 2'b01; tick(1); tmr_ovf = '0;
        expect_reg(8'h35, "R4 ovf0 set");
        tmr_ovf = 2'b10; tick(1); tmr_ovf = '0;
        expect_reg(8'hB5, "R4 ovf1 set");
        vec_ack_tmr = 2'b01; tick(1); vec_ack_tmr = '0;
        expect_reg(8'h95, "R5 ack0 only");
        tmr_ovf = 2'b10; wr_mask = 8'h80; wr_data = 8'h00; tick(1);
        tmr_ovf = '0; wr_mask = '0;
        expect_reg(8'h95, "R6 set beats write");
        vec_ack_tmr = 2'b10; tick(1); vec_ack_tmr = '0;
        expect_reg(8'h15, "R5 ack1");
        tmr_ovf = 2'b01; vec_ack_tmr = 2'b01; tick(1);
        tmr_ovf = '0; vec_ack_tmr = '0;
        expect_reg(8'h35, "R6 set beats ack");
        wr(8'h20, 8'h00);
        expect_reg(8'h15, "R4 sw clear");
        // edge mode on pin 0, active-high
        ext_pin[0] = 1'b1;
        tick(1); expect_reg(8'h15, "R7 stage1");
        tick(1); expect_reg(8'h15, "R7 stage2");
        tick(1); expect_reg(8'h17, "R7 R9 edge latched");
        ext_pin[0] = 1'b0;
        tick(4); expect_reg(8'h17, "R9 held after release");
        vec_ack_ext = 2'b10; tick(1); vec_ack_ext = '0;
        expect_reg(8'h17, "R10 other ack");
        vec_ack_ext = 2'b01; tick(1); vec_ack_ext = '0;
        expect_reg(8'h15, "R10 own ack");
        ext_pin[0] = 1'b1;
        tick(3); expect_reg(8'h17, "R9 second edge");
        wr(8'h02, 8'h00);
        expect_reg(8'h15, "R10 sw clear");
        tick(4); expect_reg(8'h15, "R9 steady no retrigger");
        ext_pin[0] = 1'b0;
        tick(3);
        // level mode on pin 1
        wr(8'h04, 8'h00);
        expect_reg(8'h11, "R3 mode1 level");
        ext_pin[1] = 1'b1;
        tick(3); expect_reg(8'h19, "R8 level follows");
        wr(8'h08, 8'h00);
        expect_reg(8'h19, "R8 write ignored");
        vec_ack_ext = 2'b10; tick(1); vec_ack_ext = '0;
        expect_reg(8'h19, "R8 ack ignored");
        ext_pin[1] = 1'b0;
        tick(3); expect_reg(8'h11, "R8 level drops");
        ext_pol[1] = 1'b0;
        tick(2); expect_reg(8'h19, "R11 active low");
        ext_pin[1] = 1'b1;
        tick(3); expect_reg(8'h11, "R11 low pol inactive");
        wr(8'h04, 8'h04);
        expect_reg(8'h15, "R3 mode1 edge");
        ext_pin[1] = 1'b0;
        tick(3); expect_reg(8'h1D, "R11 R9 falling edge");
        ext_pin[1] = 1'b1;
        tick(4); expect_reg(8'h1D, "R9 held low pol");
        tick(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule